// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives an eight-digit LED display of seven segments plus a decimal point, lighting one digit at a time. A display store outside the block holds one byte and one spare nibble per digit. The scanner picks the digit for the current time slot and turns its stored value into a segment pattern. It then drives the segment lines and the strobe line of that digit.

The digits are visited in a fixed scrambled order. Each digit is lit for a set number of system clock cycles. Between two digits there is a dark interval in which every segment line and every digit line is inactive, so the pattern of one digit never shows on the next. Each digit can be shown in one of two ways. It can be a decoded nibble, using either a hexadecimal glyph set or a restricted numeric and letter set, taken from one of two banks. It can also be a raw byte in which each bit drives one segment. A parameter sets the output polarity for common-anode or common-cathode displays. A shutdown input freezes the scan and darkens the display. A blank input darkens the display while the scan keeps running.

Top module: `led_scan_driver`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every digit and segment line is at its inactive level. The scan starts with a dark interval and then lights digit 2.
- R2: Digits are lit in the repeating order 2, 5, 1, 7, 8, 6, 4, 3. Digit n is driven on `dig_o[n-1]`.
- R3: Each digit stays lit for exactly ON_CYCLES clock cycles, and each dark interval lasts exactly GAP_CYCLES cycles. During a dark interval every digit and segment line is inactive. No more than one digit line is active at any time.
- R4: When `hex_i` is 1 and a digit is not in raw mode, its nibble codes 0 to 15 show 0-9, A, b, C, d, E, F. The active-high segment bits are a=bit0, b=bit1, c=bit2, d=bit3, e=bit4, f=bit5, g=bit6, and the decimal point is bit7 of `seg_o`.
- R5: When `hex_i` is 0 and a digit is not in raw mode, codes 0 to 9 show the digits 0-9. Code 10 shows a dash (segment g only). Codes 11 to 14 show E, H, L, P, and code 15 lights nothing.
- R6: A digit whose bit in `raw_sel_i` is 1 shows its store byte directly. The byte bits map as bit6 to a, bit5 to b, bit4 to c, bit3 to e, bit2 to g, bit1 to f and bit0 to d, where a 1 lights the segment. This choice is made per digit.
- R7: In the decoded modes, `bank_b_i`=0 takes the nibble from bits 3:0 of the store byte, and `bank_b_i`=1 takes it from the digit's nibble in `nib_b_i`. In every mode the decimal point lights when bit 7 of the store byte is 0, whichever bank is selected.
- R8: While `shdn_i` is 1, all outputs are inactive and the scan position and timing are frozen. When `shdn_i` returns to 0, the scan resumes from the point where it stopped.
- R9: While `blank_i` is 1, all outputs are inactive, but the scan timing keeps advancing.
- R10: With COMMON_ANODE=1, a lit digit line is high and a lit segment line is low. With COMMON_ANODE=0, both levels are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_i | input | 1 | Shutdown: freeze the scan and darken the display |
| blank_i | input | 1 | Darken the display while the scan runs |
| hex_i | input | 1 | 1 selects the hexadecimal glyph set, 0 selects the restricted set |
| bank_b_i | input | 1 | Source of the decoded nibble: 0 for the store byte, 1 for the second bank |
| raw_sel_i | input | 8 | Per-digit raw segment mode, bit n-1 for digit n |
| byte_i | input | 64 | Store byte per digit, bits 8n-1:8n-8 for digit n |
| nib_b_i | input | 32 | Second-bank nibble per digit, bits 4n-1:4n-4 for digit n |
| seg_o | output | 8 | Segment lines {dp,g,f,e,d,c,b,a}, polarity set by COMMON_ANODE |
| dig_o | output | 8 | Digit strobes, bit n-1 for digit n, polarity set by COMMON_ANODE |

## Verification
The outputs are a combinational function of the scan state, so a wrong slot, phase or count shows on `dig_o` at the first edge where the state goes wrong. A wrong slot lights the wrong strobe, a wrong phase puts a lit digit where a dark cycle should be or the reverse, and a bad count moves the next dark interval away from its expected cycle within one digit time. A wrong glyph or bank choice shows on `seg_o` as soon as the affected digit is lit, which is at most one full scan of eight digits and eight gaps. A freeze or resume error during shutdown shows as a shifted strobe sequence on the first digit after release.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int NDIG = 8;
    localparam int SLOT_W = 3;

    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } scan_phase_e;

    // Scan slot -> zero-based digit index (visits digits 2,5,1,7,8,6,4,3)
    function automatic logic [SLOT_W-1:0] slot_digit(input logic [SLOT_W-1:0] slot);
        logic [SLOT_W-1:0] idx;
        case (slot)
            3'd0:    idx = 3'd1;
            3'd1:    idx = 3'd4;
            3'd2:    idx = 3'd0;
            3'd3:    idx = 3'd6;
            3'd4:    idx = 3'd7;
            3'd5:    idx = 3'd5;
            3'd6:    idx = 3'd3;
            default: idx = 3'd2;
        endcase
        return idx;
    endfunction

    // Glyphs as {g,f,e,d,c,b,a}, active high
    function automatic logic [6:0] glyph_hex(input logic [3:0] code);
        logic [6:0] s;
        case (code)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

    function automatic logic [6:0] glyph_short(input logic [3:0] code);
        logic [6:0] s;
        case (code)
            4'hA:    s = 7'h40;   // dash
            4'hB:    s = 7'h79;   // E
            4'hC:    s = 7'h76;   // H
            4'hD:    s = 7'h38;   // L
            4'hE:    s = 7'h73;   // P
            4'hF:    s = 7'h00;   // dark
            default: s = glyph_hex(code);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/led_scan_timebase.sv
module led_scan_timebase
    import led_scan_pkg::*;
#(
    parameter int ON_CYCLES  = 32,
    parameter int GAP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              lit_o
);

    localparam int LONGEST = (ON_CYCLES > GAP_CYCLES) ? ON_CYCLES : GAP_CYCLES;
    localparam int CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYCLES - 1);

    typedef struct packed {
        scan_phase_e       phase;
        logic [CW-1:0]     cnt;
        logic [SLOT_W-1:0] slot;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CW-1:0] last_c;

    always_comb begin
        st_d   = st_q;
        last_c = (st_q.phase == PH_LIT) ? ON_LAST : GAP_LAST;
        if (run_i) begin
            if (st_q.cnt == last_c) begin
                st_d.cnt = '0;
                if (st_q.phase == PH_LIT) begin
                    st_d.phase = PH_DARK;
                    st_d.slot  = st_q.slot + 1'b1;
                end else begin
                    st_d.phase = PH_LIT;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_DARK, cnt: '0, slot: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;
    assign lit_o  = (st_q.phase == PH_LIT);

endmodule

// File: rtl/led_glyph_decode.sv
module led_glyph_decode
    import led_scan_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [3:0] nib_b_i,
    input  logic       raw_i,
    input  logic       hex_i,
    input  logic       bank_b_i,
    output logic [7:0] seg_o     // {dp,g,f,e,d,c,b,a}, active high
);

    logic [3:0] code_c;
    logic [6:0] body_c;

    always_comb begin
        code_c = bank_b_i ? nib_b_i : byte_i[3:0];
        if (raw_i) begin
            body_c[0] = byte_i[6];   // a
            body_c[1] = byte_i[5];   // b
            body_c[2] = byte_i[4];   // c
            body_c[3] = byte_i[0];   // d
            body_c[4] = byte_i[3];   // e
            body_c[5] = byte_i[1];   // f
            body_c[6] = byte_i[2];   // g
        end else if (hex_i) begin
            body_c = glyph_hex(code_c);
        end else begin
            body_c = glyph_short(code_c);
        end
        // point is shared by both banks and lit by a zero in bit 7
        seg_o = {~byte_i[7], body_c};
    end

endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
    import led_scan_pkg::*;
#(
    parameter int ON_CYCLES    = 32,
    parameter int GAP_CYCLES   = 4,
    parameter bit COMMON_ANODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_i,
    input  logic              blank_i,
    input  logic              hex_i,
    input  logic              bank_b_i,
    input  logic [NDIG-1:0]   raw_sel_i,
    input  logic [NDIG*8-1:0] byte_i,
    input  logic [NDIG*4-1:0] nib_b_i,
    output logic [7:0]        seg_o,
    output logic [NDIG-1:0]   dig_o
);

    logic [SLOT_W-1:0] slot_w;
    logic              lit_w;
    logic [SLOT_W-1:0] dig_idx;
    logic [7:0]        byte_arr [NDIG];
    logic [3:0]        nib_arr  [NDIG];
    logic [7:0]        seg_raw;
    logic              show;
    logic [7:0]        seg_act;
    logic [NDIG-1:0]   dig_act;

    led_scan_timebase #(
        .ON_CYCLES (ON_CYCLES),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (~shdn_i),
        .slot_o(slot_w),
        .lit_o (lit_w)
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_unpack
        assign byte_arr[g] = byte_i[g*8 +: 8];
        assign nib_arr[g]  = nib_b_i[g*4 +: 4];
    end

    assign dig_idx = slot_digit(slot_w);

    led_glyph_decode u_dec (
        .byte_i  (byte_arr[dig_idx]),
        .nib_b_i (nib_arr[dig_idx]),
        .raw_i   (raw_sel_i[dig_idx]),
        .hex_i   (hex_i),
        .bank_b_i(bank_b_i),
        .seg_o   (seg_raw)
    );

    always_comb begin
        show    = lit_w & ~shdn_i & ~blank_i;
        seg_act = show ? seg_raw : '0;
        dig_act = show ? (NDIG'(1) << dig_idx) : '0;
    end

    if (COMMON_ANODE) begin : g_anode
        assign seg_o = ~seg_act;
        assign dig_o = dig_act;
    end else begin : g_cathode
        assign seg_o = seg_act;
        assign dig_o = ~dig_act;
    end

endmodule

// File: rtl/led_scan_driver_chk.sv
module led_scan_driver_chk #(
    parameter bit COMMON_ANODE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_i,
    input logic       blank_i,
    input logic [7:0] seg_o,
    input logic [7:0] dig_o,
    input logic [2:0] slot,
    input logic       lit
);

    logic [7:0] dig_on;
    logic [7:0] seg_on;
    assign dig_on = COMMON_ANODE ? dig_o : ~dig_o;
    assign seg_on = COMMON_ANODE ? ~seg_o : seg_o;

    AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_on)); // R3
    AST_DARK_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_on == 8'h00) |-> (seg_on == 8'h00)); // R3
    AST_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_on != 8'h00) |=> (dig_on == 8'h00 || dig_on == $past(dig_on))); // R3
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != $past(slot)) |-> (slot == $past(slot) + 3'd1)); // R2
    AST_SHDN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |-> (dig_on == 8'h00 && seg_on == 8'h00)); // R8
    AST_SHDN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |=> ($stable(slot) && $stable(lit))); // R8
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> (dig_on == 8'h00 && seg_on == 8'h00)); // R9

endmodule

bind led_scan_driver led_scan_driver_chk #(.COMMON_ANODE(COMMON_ANODE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .shdn_i (shdn_i),
    .blank_i(blank_i),
    .seg_o  (seg_o),
    .dig_o  (dig_o),
    .slot   (slot_w),
    .lit    (lit_w)
);

// File: tb/tb_led_scan_driver.sv
module tb_led_scan_driver;

    localparam int ON  = 6;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shdn = 1'b0, blank = 1'b0, hex = 1'b1, bank_b = 1'b0;
    logic [7:0]  raw_sel = '0;
    logic [63:0] byte_v = '1;
    logic [31:0] nib_v = '0;
    logic [7:0]  seg_a, dig_a, seg_c, dig_c;

    always #2 clk = ~clk;

    led_scan_driver #(.ON_CYCLES(ON), .GAP_CYCLES(GAP), .COMMON_ANODE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .blank_i(blank), .hex_i(hex),
        .bank_b_i(bank_b), .raw_sel_i(raw_sel), .byte_i(byte_v), .nib_b_i(nib_v),
        .seg_o(seg_a), .dig_o(dig_a));

    led_scan_driver #(.ON_CYCLES(ON), .GAP_CYCLES(GAP), .COMMON_ANODE(1'b0)) dut_cc (
        .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .blank_i(blank), .hex_i(hex),
        .bank_b_i(bank_b), .raw_sel_i(raw_sel), .byte_i(byte_v), .nib_b_i(nib_v),
        .seg_o(seg_c), .dig_o(dig_c));

    int    n_chk = 0, n_fail = 0;
    string req = "R1";
    bit    done = 1'b0;
    int    order [8] = '{2, 5, 1, 7, 8, 6, 4, 3};
    string hex_tab [16] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg", "acdfg", "acdefg", "abc",
                            "abcdefg", "abcdfg", "abcefg", "cdefg", "adef", "bcdeg", "adefg", "aefg"};
    string alt_tab [6] = '{"g", "adefg", "bcefg", "def", "abefg", ""};

    function automatic logic [6:0] letters(string s);
        logic [6:0] v = '0;
        for (int i = 0; i < s.len(); i++) v[s[i] - 8'd97] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_seg(int d);
        logic [7:0] b = byte_v[d*8 +: 8];
        logic [3:0] code;
        logic [6:0] body;
        if (raw_sel[d]) begin
            body = {b[2], b[1], b[3], b[0], b[4], b[5], b[6]}; // g f e d c b a
        end else begin
            code = bank_b ? nib_v[d*4 +: 4] : b[3:0];
            if (hex || code < 4'd10) body = letters(hex_tab[code]);
            else body = letters(alt_tab[code - 4'd10]);
        end
        return {~b[7], body};
    endfunction

    // behavioural scan model
    int m_lit = 0, m_cnt = 0, m_slot = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lit = 0; m_cnt = 0; m_slot = 0;
        end else if (!shdn) begin
            m_cnt++;
            if (m_cnt == (m_lit ? ON : GAP)) begin
                m_cnt = 0;
                if (m_lit) m_slot = (m_slot + 1) % 8;
                m_lit = m_lit ? 0 : 1;
            end
        end
    end

    bit         cap = 1'b0;
    int         seen [$];
    logic [7:0] last_d = '0;

    always @(negedge clk) begin
        logic [7:0] ed, es;
        #1;
        if (!done) begin
            ed = '0; es = '0;
            if (rst_n && !shdn && !blank && m_lit == 1) begin
                ed = 8'(1) << (order[m_slot] - 1);
                es = exp_seg(order[m_slot] - 1);
            end
            n_chk++;
            if (dig_a !== ed || seg_a !== ~es) begin
                n_fail++;
                $display("FAIL %s anode: dig=%h seg=%h expected dig=%h seg=%h", req, dig_a, seg_a, ed, ~es);
            end
            n_chk++;
            if (dig_c !== ~ed || seg_c !== es) begin
                n_fail++;
                $display("FAIL R10 cathode: dig=%h seg=%h expected dig=%h seg=%h", dig_c, seg_c, ~ed, es);
            end
            if (cap && dig_a != 0 && dig_a != last_d)
                for (int k = 0; k < 8; k++) if (dig_a[k]) seen.push_back(k + 1);
            last_d = dig_a;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_codes(int base, logic [7:0] dp_off);
        @(negedge clk);
        for (int d = 0; d < 8; d++) byte_v[d*8 +: 8] = {dp_off[d], 3'b000, 4'(base + d)};
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, g;
        // R1: reset state
        run(3);
        #1 check(dig_a == 8'h00 && seg_a == 8'hFF, "R1 reset outputs", int'({dig_a, seg_a}), 255);
        @(negedge clk) rst_n = 1'b1;
        #1 check(dig_a == 8'h00, "R1 dark after reset", int'(dig_a), 0);

        // R2: scan order, R4 hex glyphs 0..7 then 8..15
        req = "R4";
        load_codes(0, 8'b1111_1011);
        cap = 1'b1;
        run(8 * (ON + GAP) + 4);
        cap = 1'b0;
        check(seen.size() >= 8, "R2 digits seen", seen.size(), 8);
        for (int i = 0; i < 8 && i < seen.size(); i++)
            check(seen[i] == order[i], "R2 scan order", seen[i], order[i]);
        load_codes(8, 8'b0111_1110);
        run(70);

        // R3: on time and gap length
        req = "R3";
        @(negedge clk); #1;
        while (dig_a != 0) begin @(negedge clk); #1; end
        while (dig_a == 0) begin @(negedge clk); #1; end
        n = 0;
        while (dig_a != 0) begin n++; @(negedge clk); #1; end
        g = 0;
        while (dig_a == 0) begin g++; @(negedge clk); #1; end
        check(n == ON, "R3 lit length", n, ON);
        check(g == GAP, "R3 gap length", g, GAP);

        // R5: restricted set
        req = "R5";
        @(negedge clk) hex = 1'b0;
        load_codes(8, 8'hFF);
        run(70);
        load_codes(0, 8'h0F);
        run(70);

        // R7: bank B nibbles, shared point
        req = "R7";
        @(negedge clk) begin
            nib_v = 32'h3A5C_E1F7;
            bank_b = 1'b1;
            hex = 1'b1;
        end
        run(70);
        @(negedge clk) hex = 1'b0;
        run(70);

        // R6: raw mode, mixed per digit
        req = "R6";
        @(negedge clk) begin
            bank_b = 1'b0;
            raw_sel = 8'b1010_0101;
            byte_v = 64'h7F80_55AA_0141_FE3C;
        end
        run(70);
        @(negedge clk) raw_sel = 8'hFF;
        run(70);

        // R8: shutdown mid-scan, then resume
        req = "R8";
        run(13);
        @(negedge clk) shdn = 1'b1;
        run(25);
        @(negedge clk) shdn = 1'b0;
        run(70);

        // R9: blank while scanning
        req = "R9";
        run(5);
        @(negedge clk) blank = 1'b1;
        run(30);
        @(negedge clk) blank = 1'b0;
        run(70);

        finish_run();
    end

endmodule